// File: doc/BRIEF.md
# Start-Triggered Enable Phase Sequencer

This block is the control counter for a small serial capture-and-compare path. It sits idle until it sees a one-cycle request on `startReq`. It then runs through one pass of a 4-bit count and turns that count into two enable windows, one after the other. The first window, `captureEn`, lets an 8-bit serial shift register take in bits. The second window, `compareEn`, lets the comparator stage use the captured pair. When the count reaches all ones, both enables drop. The counter then stays at that terminal value until the next request.

A request counts only if it is a single-cycle pulse. In the cycle after the request is sampled, the count sits at zero with both enables low. If the request is still high at the next edge, the pass is abandoned and the block goes back to idle. The present count is brought out on `phaseCount`, so the surrounding logic and the bench can see the terminal hold and the arming step.

Top module: `phase_seq_top`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `phaseCount` = 4'b1111 with `captureEn` and `compareEn` both low.
- R2: In idle (count 1111), a high `startReq` at an edge loads `phaseCount` to 4'b0000, and both enables stay low in that arming cycle.
- R3: If `startReq` is high again at the edge that ends the arming cycle, the block returns to idle: `phaseCount` = 4'b1111 and no enable is raised.
- R4: If `startReq` is low at the edge that ends the arming cycle, `captureEn` is high for exactly 8 consecutive cycles, while `phaseCount` steps through 0 to 7.
- R5: On the cycle right after the last capture cycle, `compareEn` rises, and it stays high while `phaseCount` steps through 8 to 14 (7 cycles).
- R6: When the count reaches 4'b1111, both enables are low, and the count holds at 1111 instead of wrapping.
- R7: `startReq` has no effect while an enable window is active: the count still advances by one on every cycle.
- R8: `captureEn` and `compareEn` are never high in the same cycle.
- R9: After a pass ends, no enable is raised and the count stays at 1111 until `startReq` is seen high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | One-cycle pass request |
| captureEn | output | 1 | Enable for the serial capture register |
| compareEn | output | 1 | Enable for the comparator stage |
| phaseCount | output | 4 | Current count, 1111 when idle |

## Verification
Most internal faults show up on `phaseCount` within one clock, because the count is visible directly. This covers a counter that skips a value or wraps past 1111, or a phase register stuck in the run state. A bad window decode would show up as a wrong enable in the same cycle as the count that triggers it. A fault in the arming logic would show up one edge after the request, as a missing zero load or a missed abort. The bench compares every output on every cycle against a behavioural model, so it reports the first wrong cycle.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ARMED = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  // strobes from control to the count datapath
  typedef struct packed {
    logic loadZero;
    logic loadTerm;
    logic advance;
    logic running;
  } ctrlStrobes_t;

endpackage

// File: rtl/phase_seq_ctrl.sv
module phase_seq_ctrl
  import phase_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         startReq,
  input  logic         atLastStep,
  output ctrlStrobes_t strobes
);

  phase_t phaseQ;
  phase_t phaseD;

  always_comb begin
    phaseD  = phaseQ;
    strobes = '0;
    unique case (phaseQ)
      PH_IDLE: begin
        if (startReq) begin
          phaseD           = PH_ARMED;
          strobes.loadZero = 1'b1;
        end
      end
      PH_ARMED: begin
        if (startReq) begin
          phaseD           = PH_IDLE;
          strobes.loadTerm = 1'b1;
        end else begin
          phaseD = PH_RUN;
        end
      end
      PH_RUN: begin
        strobes.running = 1'b1;
        strobes.advance = 1'b1;
        if (atLastStep) phaseD = PH_IDLE;
      end
      default: begin
        phaseD           = PH_IDLE;
        strobes.loadTerm = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phaseQ <= PH_IDLE;
    else     phaseQ <= phaseD;
  end

endmodule

// File: rtl/phase_seq_count.sv
module phase_seq_count
  import phase_seq_pkg::*;
#(
  parameter int COUNT_W = 4,
  parameter int CAP_LEN = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strobes,
  output logic [COUNT_W-1:0] countQ,
  output logic               atLastStep,
  output logic               captureEn,
  output logic               compareEn
);

  localparam logic [COUNT_W-1:0] TERM_VAL = {COUNT_W{1'b1}};
  localparam logic [COUNT_W-1:0] LAST_VAL = TERM_VAL - 1'b1;
  localparam logic [COUNT_W-1:0] CAP_END  = COUNT_W'(CAP_LEN);

  always_ff @(posedge clk) begin
    if (rst || strobes.loadTerm) countQ <= TERM_VAL;
    else if (strobes.loadZero)   countQ <= '0;
    else if (strobes.advance)    countQ <= countQ + 1'b1;
  end

  assign atLastStep = (countQ == LAST_VAL);

  // window decode: capture below CAP_END, compare from there to terminal
  always_comb begin
    captureEn = 1'b0;
    compareEn = 1'b0;
    if (strobes.running) begin
      if (countQ < CAP_END)       captureEn = 1'b1;
      else if (countQ != TERM_VAL) compareEn = 1'b1;
    end
  end

endmodule

// File: rtl/phase_seq_top.sv
module phase_seq_top
  import phase_seq_pkg::*;
#(
  parameter int COUNT_W = 4,
  parameter int CAP_LEN = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               startReq,
  output logic               captureEn,
  output logic               compareEn,
  output logic [COUNT_W-1:0] phaseCount
);

  ctrlStrobes_t strobes;
  logic         atLastStep;

  phase_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .startReq   (startReq),
    .atLastStep (atLastStep),
    .strobes    (strobes)
  );

  phase_seq_count #(
    .COUNT_W (COUNT_W),
    .CAP_LEN (CAP_LEN)
  ) u_count (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .countQ     (phaseCount),
    .atLastStep (atLastStep),
    .captureEn  (captureEn),
    .compareEn  (compareEn)
  );

endmodule

// File: rtl/phase_seq_checker.sv
module phase_seq_checker #(
  parameter int COUNT_W = 4,
  parameter int CAP_LEN = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               startReq,
  input logic               captureEn,
  input logic               compareEn,
  input logic [COUNT_W-1:0] phaseCount
);

  localparam logic [COUNT_W-1:0] TERM_VAL = {COUNT_W{1'b1}};
  localparam logic [COUNT_W-1:0] LAST_VAL = TERM_VAL - 1'b1;
  localparam logic [COUNT_W-1:0] CAP_LAST = COUNT_W'(CAP_LEN - 1);
  localparam logic [COUNT_W-1:0] CMP_FIRST = COUNT_W'(CAP_LEN);

  logic quiet;
  assign quiet = !captureEn && !compareEn;

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (phaseCount == TERM_VAL && quiet));

  assert_arm_load_R2: assert property (@(posedge clk) disable iff (rst)
    (phaseCount == TERM_VAL && quiet && startReq) |=> (phaseCount == '0 && quiet));

  assert_abort_R3: assert property (@(posedge clk) disable iff (rst)
    (phaseCount == '0 && quiet && startReq) |=> (phaseCount == TERM_VAL && quiet));

  assert_capture_start_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(captureEn) |-> (phaseCount == '0));

  assert_capture_range_R4: assert property (@(posedge clk) disable iff (rst)
    captureEn |-> (phaseCount <= CAP_LAST));

  assert_handover_R5: assert property (@(posedge clk) disable iff (rst)
    (captureEn && phaseCount == CAP_LAST) |=> (compareEn && phaseCount == CMP_FIRST));

  assert_terminal_R6: assert property (@(posedge clk) disable iff (rst)
    (compareEn && phaseCount == LAST_VAL) |=> (phaseCount == TERM_VAL && quiet));

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (captureEn || compareEn) |=> (phaseCount == $past(phaseCount) + 1'b1));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(captureEn && compareEn));

  assert_no_retrigger_R9: assert property (@(posedge clk) disable iff (rst)
    (phaseCount == TERM_VAL && !startReq) |=> (phaseCount == TERM_VAL && quiet));

endmodule

bind phase_seq_top phase_seq_checker #(
  .COUNT_W (COUNT_W),
  .CAP_LEN (CAP_LEN)
) u_checker (
  .clk        (clk),
  .rst        (rst),
  .startReq   (startReq),
  .captureEn  (captureEn),
  .compareEn  (compareEn),
  .phaseCount (phaseCount)
);

// File: tb/phase_seq_top_bench.sv
module phase_seq_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       startReq = 1'b0;
  logic       captureEn;
  logic       compareEn;
  logic [3:0] phaseCount;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  bit modelValid = 1'b0;

  // reference model: 0 idle, 1 armed, 2 run
  int    mState = 0;
  int    mCount = 15;
  string mTag   = "R1";

  always #(CLK_PERIOD / 2) clk = ~clk;

  phase_seq_top u_phase_seq_top (
    .clk        (clk),
    .rst        (rst),
    .startReq   (startReq),
    .captureEn  (captureEn),
    .compareEn  (compareEn),
    .phaseCount (phaseCount)
  );

  always @(posedge clk) begin
    if (rst) begin
      mState = 0; mCount = 15; mTag = "R1";
      modelValid = 1'b1;
    end else begin
      case (mState)
        0: begin
          if (startReq) begin mState = 1; mCount = 0; mTag = "R2"; end
          else if (mTag != "R1" && mTag != "R3") mTag = "R9";
        end
        1: begin
          if (startReq) begin mState = 0; mCount = 15; mTag = "R3"; end
          else begin mState = 2; mTag = "R4"; end
        end
        default: begin
          mCount = mCount + 1;
          if (mCount == 15) begin mState = 0; mTag = "R6"; end
          else if (startReq) mTag = "R7";
          else if (mCount >= 8) mTag = "R5";
          else mTag = "R4";
        end
      endcase
    end
  end

  task automatic check(input string tag, input int act, input int exp, input string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (modelValid && !finished) begin
      check(mTag, int'(phaseCount), mCount, "phaseCount");
      check(mTag, int'(captureEn), (mState == 2 && mCount < 8) ? 1 : 0, "captureEn");
      check(mTag, int'(compareEn), (mState == 2 && mCount >= 8) ? 1 : 0, "compareEn");
      check("R8", int'(captureEn && compareEn), 0, "both enables");
    end
  end

  task automatic idleFor(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int width);
    @(negedge clk);
    startReq = 1'b1;
    for (int i = 1; i < width; i++) @(negedge clk);
    @(negedge clk);
    startReq = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idleFor(5);          // R1 reset state holds, R9 quiet
    pulse(1);            // R2, R4, R5, R6 full pass
    idleFor(22);         // R9 no retrigger
    pulse(2);            // R3 abort
    idleFor(6);
    pulse(1);            // pass with noise during run, R7
    idleFor(3);
    startReq = 1'b1; @(negedge clk); startReq = 1'b0;
    idleFor(6);
    startReq = 1'b1; @(negedge clk); startReq = 1'b0;
    idleFor(15);
    pulse(4);            // held request: arm, abort, arm, abort
    idleFor(5);
    pulse(1);            // reset in mid-pass, R1
    idleFor(4);
    rst = 1'b1; idleFor(2); rst = 1'b0;
    idleFor(5);
    pulse(1);            // clean final pass
    idleFor(25);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule